// File: doc/BRIEF.md
# Lockable split work RAM controller

A 1 KB on-chip work RAM reached by the CPU through the window $7000-$7FFF. Inside the window, address bit A9 picks one of two 512-byte halves and A8:A0 pick the byte. A11:A10 are not decoded, so the 1 KB image repeats four times across the window. Every access is gated by two kinds of permission. The first is a master enable that software sets through bit 5 of the bank-select register, and once set it stays set until reset. The second is a protect register that holds an independent read permission and write permission for each half.

Reads are synchronous. A read strobe in one cycle gives, on the next cycle, the byte on `rd_data_o` with `rd_oe_o` high when the access is allowed. When the access is refused, `rd_oe_o` is low and the data lines are zero, so the system leaves the CPU data bus undriven. A write that is refused leaves the RAM unchanged. The RAM array has no reset, so its contents survive a reset. The two control registers share the CPU bus with the RAM and are decoded from the upper address bits and A0.

Top module: `wram_ctrl`

## Requirements
- R1: Reset (rst_ni low) clears the master enable and all protect bits. During reset and after it, `rd_oe_o` is 0 and `rd_data_o` is 0 until an allowed read is made.
- R2: A write with A15:A13=100 and A0=0 whose data bit 5 is 1 sets the master enable. Later writes to that register with bit 5 at 0 leave it set.
- R3: While the master enable is clear, every RAM read gives `rd_oe_o`=0 and every RAM write leaves the RAM contents unchanged. The RAM keeps its contents across reset.
- R4: A write with A15:A13=101 and A0=1 loads the protect register from data bits 7:4, whatever the master enable. Bit 4 permits writes and bit 5 permits reads of the lower half (A9=0).
- R5: In the protect register, bit 6 permits writes and bit 7 permits reads of the upper half (A9=1).
- R6: Protect data bits 3:0 grant no permission.
- R7: A15:A12=0111 selects the RAM. A9 selects the half and A8:A0 the byte. A11:A10 are ignored, so each byte appears at four addresses.
- R8: `rd_oe_o` and `rd_data_o` reflect a read strobe in the following cycle only. In any cycle where `rd_oe_o` is 0, `rd_data_o` is 0.
- R9: A write to a half whose write permission is clear leaves that half unchanged, even when its read permission is set.
- R10: Accesses outside $7000-$7FFF never read or write the RAM. A write with A15:A13=100 and A0=1 does not touch the master enable, and a write with A15:A13=101 and A0=0 does not touch the protect register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_wr_i | input | 1 | Write strobe, one cycle per write |
| cpu_rd_i | input | 1 | Read strobe, one cycle per read |
| rd_data_o | output | 8 | Read data, valid the cycle after the strobe |
| rd_oe_o | output | 1 | High when rd_data_o must drive the CPU bus |

## Verification
The hardest case to reach is a refused write whose effect can only be seen later. The bench has to grant read permission without write permission on the same half, attempt an overwrite, and then read the old byte back. It does the same across a reset with the master enable cleared, relying on the array's lack of reset. The stimulus table walks the protect register through the codes A0, 50 and 0F, so that read-only, write-only and low-nibble-only settings each meet a write and a read. Directed resets then show that the sticky enable clears only through rst_ni, while the stored bytes stay in place.

// File: rtl/wram_pkg.sv
package wram_pkg;
  typedef enum logic [1:0] {
    REG_NONE    = 2'd0,
    REG_BANKSEL = 2'd1,
    REG_PROTECT = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/wram_regs.sv
module wram_regs
  import wram_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_HALVES = 2,
  parameter int EN_BIT     = 5,
  parameter int PROT_LSB   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  reg_sel_e                sel_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic                    en_o,
  output logic [2*NUM_HALVES-1:0] prot_o
);
  localparam int PROT_W = 2 * NUM_HALVES;

  logic                    en_q;
  logic [PROT_W-1:0]       prot_q;
  logic [DATA_W-1:0]       unused_wdata;

  assign unused_wdata = wdata_i;

  // master enable: set-only, cleared by reset alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           en_q <= 1'b0;
    else if (wr_i && sel_i == REG_BANKSEL && wdata_i[EN_BIT]) en_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              prot_q <= '0;
    else if (wr_i && sel_i == REG_PROTECT)    prot_q <= wdata_i[PROT_LSB +: PROT_W];
  end

  assign en_o   = en_q;
  assign prot_o = prot_q;
endmodule

// File: rtl/wram_gate.sv
module wram_gate #(
  parameter int NUM_HALVES = 2,
  parameter int HSEL_W     = 1
) (
  input  logic                    en_i,
  input  logic                    in_win_i,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic [HSEL_W-1:0]       half_i,
  input  logic [2*NUM_HALVES-1:0] prot_i,
  output logic                    rd_ok_o,
  output logic                    wr_ok_o
);
  logic [NUM_HALVES-1:0] rd_allow;
  logic [NUM_HALVES-1:0] wr_allow;

  // per half: even bit = write permission, odd bit = read permission
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    assign wr_allow[h] = prot_i[2*h];
    assign rd_allow[h] = prot_i[2*h+1];
  end

  assign rd_ok_o = en_i && in_win_i && rd_i && rd_allow[half_i];
  assign wr_ok_o = en_i && in_win_i && wr_i && wr_allow[half_i];
endmodule

// File: rtl/wram_store.sv
module wram_store #(
  parameter int DATA_W = 8,
  parameter int AW     = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // array holds no reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem[addr_i];
    else           rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/wram_ctrl.sv
module wram_ctrl
  import wram_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int HALF_AW    = 9,
  parameter int NUM_HALVES = 2,
  parameter int PAGE_W     = 3,
  parameter logic [PAGE_W-1:0] BANKSEL_PAGE = 3'h4,
  parameter logic [PAGE_W-1:0] PROTECT_PAGE = 3'h5,
  parameter int WIN_W      = 4,
  parameter logic [WIN_W-1:0] WIN_PAGE = 4'h7,
  parameter int EN_BIT     = 5,
  parameter int PROT_LSB   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              cpu_wr_i,
  input  logic              cpu_rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_oe_o
);
  localparam int HSEL_W = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1;
  localparam int RAM_AW = HALF_AW + HSEL_W;
  localparam int PROT_W = 2 * NUM_HALVES;

  reg_sel_e            reg_sel;
  logic                en_q;
  logic [PROT_W-1:0]   prot_q;
  logic                in_win;
  logic                rd_ok, wr_ok;
  logic                oe_q;
  logic [HSEL_W-1:0]   half_sel;
  logic [ADDR_W-1:0]   unused_addr;

  assign unused_addr = cpu_addr_i;

  always_comb begin
    reg_sel = REG_NONE;
    if (cpu_addr_i[ADDR_W-1 -: PAGE_W] == BANKSEL_PAGE && !cpu_addr_i[0]) reg_sel = REG_BANKSEL;
    if (cpu_addr_i[ADDR_W-1 -: PAGE_W] == PROTECT_PAGE &&  cpu_addr_i[0]) reg_sel = REG_PROTECT;
  end

  assign in_win   = cpu_addr_i[ADDR_W-1 -: WIN_W] == WIN_PAGE;
  assign half_sel = cpu_addr_i[HALF_AW +: HSEL_W];

  wram_regs #(
    .DATA_W(DATA_W), .NUM_HALVES(NUM_HALVES), .EN_BIT(EN_BIT), .PROT_LSB(PROT_LSB)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(cpu_wr_i), .sel_i(reg_sel),
    .wdata_i(cpu_wdata_i), .en_o(en_q), .prot_o(prot_q)
  );

  wram_gate #(.NUM_HALVES(NUM_HALVES), .HSEL_W(HSEL_W)) u_gate (
    .en_i(en_q), .in_win_i(in_win), .rd_i(cpu_rd_i), .wr_i(cpu_wr_i),
    .half_i(half_sel), .prot_i(prot_q), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok)
  );

  wram_store #(.DATA_W(DATA_W), .AW(RAM_AW)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_ok), .re_i(rd_ok),
    .addr_i(cpu_addr_i[RAM_AW-1:0]), .wdata_i(cpu_wdata_i), .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= rd_ok;
  end

  assign rd_oe_o = oe_q;
endmodule

// File: rtl/wram_ctrl_chk.sv
module wram_ctrl_chk #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int HALF_AW    = 9,
  parameter int NUM_HALVES = 2,
  parameter int EN_BIT     = 5
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [ADDR_W-1:0]       cpu_addr_i,
  input logic [DATA_W-1:0]       cpu_wdata_i,
  input logic                    cpu_wr_i,
  input logic                    cpu_rd_i,
  input logic [DATA_W-1:0]       rd_data_o,
  input logic                    rd_oe_o,
  input logic                    en_q,
  input logic [2*NUM_HALVES-1:0] prot_q
);
  logic bsel_set, prot_wr, rd_perm, win;

  assign bsel_set = cpu_wr_i && cpu_addr_i[15:13] == 3'b100 && !cpu_addr_i[0] && cpu_wdata_i[EN_BIT];
  assign prot_wr  = cpu_wr_i && cpu_addr_i[15:13] == 3'b101 && cpu_addr_i[0];
  assign rd_perm  = prot_q[{cpu_addr_i[HALF_AW], 1'b1}];
  assign win      = cpu_addr_i[15:12] == 4'h7;

  p_en_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
  p_en_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> $past(bsel_set));
  p_oe_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> $past(en_q));
  p_prot_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_wr |=> $stable(prot_q));
  p_oe_read_perm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> $past(rd_perm));
  p_oe_needs_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> $past(cpu_rd_i));
  p_quiet_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_oe_o |-> rd_data_o == '0);
  p_oe_in_window_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> $past(win));
endmodule

bind wram_ctrl wram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_AW(HALF_AW), .NUM_HALVES(NUM_HALVES), .EN_BIT(EN_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
  .cpu_wr_i(cpu_wr_i), .cpu_rd_i(cpu_rd_i), .rd_data_o(rd_data_o), .rd_oe_o(rd_oe_o),
  .en_q(en_q), .prot_q(prot_q)
);

// File: tb/tb_wram_ctrl.sv
`timescale 1ns/1ps
module tb_wram_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic        oe;
  int          n_checks = 0, n_errors = 0;

  always #2.5 clk = ~clk;

  wram_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_wr_i(wr), .cpu_rd_i(rd), .rd_data_o(rdata), .rd_oe_o(oe)
  );

  // {op(1: read-check, 0: write), addr, data/expected, expected oe, req}
  localparam int NV = 40;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1,16'h7000,8'h00,1'b0,4'd3},  // R3 nothing enabled
    {1'b0,16'h8000,8'h20,1'b0,4'd2},  // R2 set master enable
    {1'b0,16'h7000,8'h11,1'b0,4'd9},  // refused, protect still 0
    {1'b0,16'hA001,8'h30,1'b0,4'd4},  // R4 lower read+write
    {1'b0,16'h7000,8'h11,1'b0,4'd4},
    {1'b1,16'h7000,8'h11,1'b1,4'd4},
    {1'b0,16'h7200,8'h22,1'b0,4'd9},  // R9 upper write refused
    {1'b1,16'h7200,8'h00,1'b0,4'd5},  // R5 upper read refused
    {1'b0,16'hA001,8'hF0,1'b0,4'd5},
    {1'b0,16'h7200,8'h22,1'b0,4'd5},
    {1'b1,16'h7200,8'h22,1'b1,4'd5},
    {1'b1,16'h7C00,8'h11,1'b1,4'd7},  // R7 mirror
    {1'b1,16'h7E00,8'h22,1'b1,4'd7},
    {1'b0,16'h71FF,8'h5A,1'b0,4'd7},
    {1'b1,16'h7DFF,8'h5A,1'b1,4'd7},
    {1'b1,16'h7000,8'h11,1'b1,4'd7},
    {1'b0,16'hA001,8'hA0,1'b0,4'd9},  // R9 read-only both halves
    {1'b0,16'h7000,8'h99,1'b0,4'd9},
    {1'b0,16'h7200,8'h77,1'b0,4'd9},
    {1'b1,16'h7000,8'h11,1'b1,4'd9},
    {1'b1,16'h7200,8'h22,1'b1,4'd9},
    {1'b0,16'hA001,8'h50,1'b0,4'd4},  // write-only both halves
    {1'b1,16'h7000,8'h00,1'b0,4'd4},
    {1'b0,16'h7400,8'h33,1'b0,4'd7},  // mirror write lands at 7000
    {1'b0,16'hA001,8'h0F,1'b0,4'd6},  // R6 low nibble only
    {1'b1,16'h7000,8'h00,1'b0,4'd6},
    {1'b1,16'h7200,8'h00,1'b0,4'd6},
    {1'b0,16'hA001,8'hF0,1'b0,4'd6},
    {1'b1,16'h7000,8'h33,1'b1,4'd7},
    {1'b0,16'h8000,8'h00,1'b0,4'd2},  // R2 cannot clear
    {1'b0,16'h8000,8'hDF,1'b0,4'd2},
    {1'b1,16'h7000,8'h33,1'b1,4'd2},
    {1'b0,16'h8001,8'h00,1'b0,4'd10}, // R10 wrong parity
    {1'b0,16'hA000,8'h00,1'b0,4'd10},
    {1'b1,16'h7200,8'h22,1'b1,4'd10},
    {1'b0,16'h6000,8'h44,1'b0,4'd10}, // outside window
    {1'b1,16'h6000,8'h00,1'b0,4'd10},
    {1'b1,16'h7000,8'h33,1'b1,4'd10},
    {1'b0,16'hBFFF,8'h30,1'b0,4'd4},  // odd address anywhere in page
    {1'b1,16'h7200,8'h00,1'b0,4'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic o, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; o = oe; d = rdata;
  endtask

  task automatic read_expect(input logic [15:0] a, input logic eo, input logic [7:0] ed, input string req);
    logic o; logic [7:0] d;
    bus_read(a, o, d);
    check(o == eo, req, o, eo);
    check(d == (eo ? ed : 8'h00), req, d, eo ? ed : 8'h00);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(oe == 1'b0, "R1 oe in reset", oe, 0);
    check(rdata == 8'h00, "R1 data in reset", rdata, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic op, eo; logic [15:0] a; logic [7:0] d; logic [3:0] rq;
      {op, a, d, eo, rq} = VEC[i];
      if (op) read_expect(a, eo, d, $sformatf("R%0d vec %0d", rq, i));
      else    bus_write(a, d);
    end

    // R8: the cycle after a granted read returns to idle
    read_expect(16'h7000, 1'b1, 8'h33, "R8 granted read");
    @(negedge clk);
    check(oe == 1'b0, "R8 idle oe", oe, 0);
    check(rdata == 8'h00, "R8 idle data", rdata, 0);

    // R1: reset clears the sticky enable
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    bus_write(16'hA001, 8'hF0);
    read_expect(16'h7000, 1'b0, 8'h00, "R1 enable cleared by reset");
    // R3: write refused while master enable clear; contents survive reset
    bus_write(16'h7000, 8'h66);
    bus_write(16'h8000, 8'h20);
    read_expect(16'h7000, 1'b1, 8'h33, "R3 write ignored while disabled");

    // R1: reset clears the protect register
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    bus_write(16'h8000, 8'h20);
    read_expect(16'h7000, 1'b0, 8'h00, "R1 protect cleared by reset");
    bus_write(16'hA001, 8'h20);
    read_expect(16'h7000, 1'b1, 8'h33, "R4 read-only lower half");

    finish_run();
  end
endmodule